// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures how much of one fixed frequency is present in a frame of ADC samples. A start pulse from the host begins a frame. The block then waits out the ADC's pipeline delay and captures 128 consecutive unsigned samples. It multiplies each sample by a cosine coefficient and by a sine coefficient for frequency bin 6 of a 128-point transform. The products go into a real accumulator and an imaginary accumulator.

The coefficients are signed Q1.15 values held in a table that is built at elaboration time. A registered index walks through the table in step with the incoming samples. The multiplier is followed by a parameterised delay chain. A valid bit travels down this chain beside each product, so every product reaches the accumulators exactly once. When the last product has been added, the block scales both sums to 32 bits. It raises a one-cycle done flag and holds the two results until the host starts another frame.

Top module: `bin_correlator`

## Requirements
- R1: After reset, both result outputs read 0 and the done flag is low.
- R2: Table entry k holds the cosine coefficient round(32767·cos(2π·6·k/128)) and the sine coefficient round(32767·sin(2π·6·k/128)), with halves rounded away from zero. Index k=0 therefore holds a cosine of 32767.
- R3: Let t be the first rising clock edge at which start is sampled high. The block captures samples at edges t+9 through t+136: 2 edges for the synchroniser and 7 for the ADC delay. Sample n is taken at edge t+9+n and uses coefficient index n. Values present at any other edge have no effect.
- R4: The real sum is Σ x[n]·cos_k[n] and the imaginary sum is −Σ x[n]·sin_k[n]. Each sample x[n] is treated as unsigned, and each of the 128 products is added exactly once.
- R5: Each output is its 40-bit signed sum shifted right arithmetically by 8 bits. Full-scale input (all samples 65535) gives the exact result, with no wrap.
- R6: The done flag is high only for the cycle that follows edge t+142. The final results become visible at that same edge.
- R7: Both sums are cleared when a frame begins, so a frame's results never include products from an earlier frame.
- R8: A start that is detected while a frame is in progress is ignored. This holds up to and including the edge at which done is raised.
- R9: After done, the outputs keep their values until the next frame begins.
- R10: The start input is edge-detected. Holding start high for many cycles runs exactly one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request, asynchronous to clk |
| adc_i | input | 16 | Unsigned ADC sample |
| re_o | output | 32 | Scaled real result, signed |
| im_o | output | 32 | Scaled imaginary result, signed |
| done_o | output | 1 | One-cycle flag marking a completed frame |

## Verification
The bench sweeps a full-scale impulse across all 128 sample positions, with a filler value driven outside the capture window. A design whose delay count is off by one, or whose coefficient index is skewed against the sample, returns the wrong table entry or picks up the filler. Frames carrying a bin-6 tone, a bin-11 tone, a ramp and full-scale input each expose a different error. A product accumulated twice or dropped changes the sums, a wrong sign on the imaginary path flips it, and accumulators that are too narrow wrap. A start pulse fired mid-frame, another fired at the done edge, and a start held high for the whole frame all target a design that re-arms itself or clears its accumulators. Such a design would produce a second done or corrupt results. A zero frame placed after a loud one catches accumulators that are not cleared between frames.

// File: rtl/bin_correlator.sv
module bin_correlator #(
  parameter int N         = 128,
  parameter int BIN       = 6,
  parameter int SW        = 16,
  parameter int CW        = 16,
  parameter int ADC_DELAY = 7,
  parameter int MUL_LAT   = 5,
  parameter int AW        = 40,
  parameter int OW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [SW-1:0]        adc_i,
  output logic signed [OW-1:0] re_o,
  output logic signed [OW-1:0] im_o,
  output logic                 done_o
);
  localparam int  KW    = $clog2(N);
  localparam int  PW    = CW + SW + 1;
  localparam int  LAST  = ADC_DELAY - 1 + N - 1;
  localparam int  CNTW  = $clog2(LAST + 2);
  localparam int  SHIFT = AW - OW;
  localparam real PI    = 3.14159265358979323846;

  function automatic logic signed [CW-1:0] qcoef(input int k, input bit sn);
    real ang, v;
    ang = 2.0 * PI * real'((BIN * k) % N) / real'(N);
    v   = (sn ? $sin(ang) : $cos(ang)) * real'((2 ** (CW - 1)) - 1);
    return CW'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  logic signed [CW-1:0] cos_tab [N];
  logic signed [CW-1:0] sin_tab [N];
  for (genvar g = 0; g < N; g++) begin : g_tab
    assign cos_tab[g] = qcoef(g, 1'b0);
    assign sin_tab[g] = qcoef(g, 1'b1);
  end

  logic [2:0]      st_q;
  logic            busy;
  logic [CNTW-1:0] cnt;
  logic            rise, go, take, at_last, fin, fin_last;
  logic [KW-1:0]   kidx;

  assign rise    = st_q[1] & ~st_q[2];
  assign go      = rise & ~busy;
  assign take    = busy && cnt >= CNTW'(ADC_DELAY - 1) && cnt <= CNTW'(LAST);
  assign at_last = cnt == CNTW'(LAST);
  assign kidx    = KW'(cnt - CNTW'(ADC_DELAY - 1));

  logic [SW-1:0]        s_q;
  logic signed [CW-1:0] c_q, n_q;
  logic                 v0, l0;
  logic signed [PW-1:0] pc [MUL_LAT];
  logic signed [PW-1:0] ps [MUL_LAT];
  logic [MUL_LAT-1:0]   pv, pl;
  logic signed [AW-1:0] acc_re, acc_im;

  assign fin      = pv[MUL_LAT-1];
  assign fin_last = fin & pl[MUL_LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      st_q <= {st_q[1:0], start_i};
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else begin
        if (busy && cnt <= CNTW'(LAST)) cnt <= cnt + 1'b1;
        if (fin_last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q <= '0;
      c_q <= '0;
      n_q <= '0;
      v0  <= 1'b0;
      l0  <= 1'b0;
      pv  <= '0;
      pl  <= '0;
      for (int i = 0; i < MUL_LAT; i++) begin
        pc[i] <= '0;
        ps[i] <= '0;
      end
    end else begin
      v0 <= take;
      l0 <= take & at_last;
      if (take) begin
        s_q <= adc_i;
        c_q <= cos_tab[kidx];
        n_q <= sin_tab[kidx];
      end
      pc[0] <= c_q * $signed({1'b0, s_q});
      ps[0] <= n_q * $signed({1'b0, s_q});
      pv    <= {pv[MUL_LAT-2:0], v0};
      pl    <= {pl[MUL_LAT-2:0], l0};
      for (int i = 1; i < MUL_LAT; i++) begin
        pc[i] <= pc[i-1];
        ps[i] <= ps[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_re <= '0;
      acc_im <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fin_last;
      if (go) begin
        acc_re <= '0;
        acc_im <= '0;
      end else if (fin) begin
        acc_re <= acc_re + {{(AW-PW){pc[MUL_LAT-1][PW-1]}}, pc[MUL_LAT-1]};
        acc_im <= acc_im - {{(AW-PW){ps[MUL_LAT-1][PW-1]}}, ps[MUL_LAT-1]};
      end
    end
  end

  assign re_o = acc_re[AW-1:SHIFT];
  assign im_o = acc_im[AW-1:SHIFT];
  wire unused_low = &{1'b0, acc_re[SHIFT-1:0], acc_im[SHIFT-1:0]};

  logic [KW:0] n_acc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   n_acc <= '0;
    else if (go)  n_acc <= '0;
    else if (fin) n_acc <= n_acc + 1'b1;
  end

  a_r4_each_product_once: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> n_acc == (KW+1)'(N));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (re_o == '0 && im_o == '0));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !rise) |=> ($stable(re_o) && $stable(im_o)));
  a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin_last) |=> busy);
endmodule

// File: tb/sim_bin_correlator.sv
`timescale 1ns/1ps
module sim_bin_correlator;
  localparam int  N  = 128;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] adc = '0;
  logic signed [31:0] re, im;
  logic done;
  int errors = 0, checks = 0;
  logic [15:0] xs [N];

  always #2.5 clk = ~clk;

  bin_correlator u0 (.clk(clk), .rst_n(rst_n), .start_i(start), .adc_i(adc),
                     .re_o(re), .im_o(im), .done_o(done));

  function automatic longint coefq(input int k, input bit sn);
    real ang, v;
    ang = 2.0 * PI * real'((6 * k) % N) / real'(N);
    v   = (sn ? $sin(ang) : $cos(ang)) * 32767.0;
    return longint'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input string tag, input int restart_at, input int hold_len);
    longint sr = 0, si = 0, er, ei;
    int ndone = 0;
    for (int n = 0; n < N; n++) begin
      sr += longint'(xs[n]) * coefq(n, 1'b0);
      si -= longint'(xs[n]) * coefq(n, 1'b1);
    end
    er = longint'($signed(32'(sr >>> 8)));
    ei = longint'($signed(32'(si >>> 8)));
    for (int j = 0; j <= 175; j++) begin
      @(negedge clk);
      if (j >= 1 && done) ndone++;
      if (j == 142) chk({tag, " R6 done early"}, longint'(done), 0);
      if (j == 143) begin
        chk({tag, " R6 done"}, longint'(done), 1);
        chk({tag, " R4 real"}, longint'(re), er);
        chk({tag, " R4 imag"}, longint'(im), ei);
      end
      if (j == 144) chk({tag, " R6 done width"}, longint'(done), 0);
      if (j == 175) begin
        chk({tag, " R9 real hold"}, longint'(re), er);
        chk({tag, " R9 imag hold"}, longint'(im), ei);
      end
      start = (j < 3) || (restart_at >= 0 && j >= restart_at && j < restart_at + 3) || (j < hold_len);
      adc   = (j >= 9 && j < 9 + N) ? xs[j-9] : 16'hBEEF;
    end
    chk({tag, " R6 R8 single done"}, longint'(ndone), 1);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 reset real", longint'(re), 0);
    chk("R1 reset imag", longint'(im), 0);
    chk("R1 reset done", longint'(done), 0);

    for (int k = 0; k < N; k++) begin
      for (int n = 0; n < N; n++) xs[n] = (n == k) ? 16'hFFFF : 16'h0000;
      run_frame($sformatf("R2 R3 impulse k=%0d", k), -1, 0);
    end

    for (int n = 0; n < N; n++)
      xs[n] = 16'(32768 + $rtoi(30000.0 * $cos(2.0 * PI * 6.0 * n / N + 0.3)));
    run_frame("R4 R5 bin6 tone", -1, 0);

    for (int n = 0; n < N; n++)
      xs[n] = 16'(32768 + $rtoi(30000.0 * $sin(2.0 * PI * 11.0 * n / N)));
    run_frame("R4 bin11 tone", -1, 0);

    for (int n = 0; n < N; n++) xs[n] = 16'hFFFF;
    run_frame("R5 full scale", -1, 0);

    for (int n = 0; n < N; n++) xs[n] = 16'(n * 512);
    run_frame("R8 ramp restart mid", 50, 0);

    for (int n = 0; n < N; n++) xs[n] = 16'h0000;
    run_frame("R7 zero after loud", -1, 0);

    for (int n = 0; n < N; n++)
      xs[n] = 16'(32768 + $rtoi(30000.0 * $cos(2.0 * PI * 6.0 * n / N)));
    run_frame("R8 restart at done", 140, 0);

    for (int n = 0; n < N; n++)
      xs[n] = 16'(32768 + $rtoi(20000.0 * $sin(2.0 * PI * 11.0 * n / N + 1.0)));
    run_frame("R10 held start", -1, 175);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule